// File: doc/BRIEF.md
# Bus Idle Free-Time Gate

This block decides when the local transmitter of a single-wire consumer-electronics control bus may begin a new frame. It counts half-bit-period ticks while the shared line stays high (idle) and raises a grant once the idle time reaches a threshold. The transmitter drives its start bit only while the grant is high. Bit timing, arbitration and byte transfer stay outside this block.

The threshold comes from a 3-bit free-time setting. A nonzero setting n gives a fixed threshold of 2n-1 half-bit ticks, which is 0.5 to 6.5 bit periods. Setting 0 gives a default threshold that depends on the context of the pending frame. A retry needs 2.5 periods. A new initiator needs 4.5 periods. The same initiator sending again after its own frame needs 6.5 periods.

A start-option bit selects when counting begins. With the bit at 0, counting starts when software requests a start of message. With the bit at 1, counting starts automatically when a transmission or reception ends, so the idle time is already measured by the time software asks to send.

Top module: `cec_free_time_timer`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `grant` is low.
- R2: A nonzero `free_sel` value n produces a threshold of exactly 2n-1 idle `half_tick` pulses. The grant rises in the clock cycle after the pulse that reaches the threshold, and stays low after one pulse fewer.
- R3: When `free_sel` is 0, the threshold is 5 ticks if `ctx_retry` is 1, including when `ctx_new_init` is also 1. It is 9 ticks if only `ctx_new_init` is 1, and 13 ticks if both are 0.
- R4: With `auto_start` = 0, counting starts from zero when `sw_start_req` goes high. Ticks that arrive while there is no request are not counted. Withdrawing the request while counting returns the timer to idle.
- R5: With `auto_start` = 1, counting starts from zero on a `tx_end` or `rx_end` pulse. Ticks before the first such pulse are not counted, even while a request is held. An end pulse during counting restarts the count.
- R6: A low line (`line_idle` = 0) in any cycle before the grant clears the count to zero, and no grant can rise in the following cycle.
- R7: Once high, the grant stays high until `frame_started` or a dropped `sw_start_req`, and is low in the next cycle.
- R8: The grant rises only while `sw_start_req` is high. In auto-start mode, an idle time that is already met gives the grant one cycle after the request arrives.
- R9: With `auto_start` = 0, `tx_end` and `rx_end` pulses have no effect on a count in progress.
- R10: The idle count saturates at its maximum and never wraps. A long idle time in auto-start mode therefore still meets the 13-tick threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_sel | input | 3 | Free-time setting; 0 selects the context default |
| auto_start | input | 1 | 0: count from the software request; 1: count from the end of a frame |
| half_tick | input | 1 | One-cycle pulse every half nominal bit period |
| sw_start_req | input | 1 | Software start-of-message request, held as a level |
| tx_end | input | 1 | Pulse at the end of a transmitted frame |
| rx_end | input | 1 | Pulse at the end of a received frame |
| line_idle | input | 1 | 1 while the bus line is high |
| ctx_retry | input | 1 | Pending frame is a retry |
| ctx_new_init | input | 1 | Pending frame comes from a new initiator |
| frame_started | input | 1 | Transmitter has begun driving the start bit |
| grant | output | 1 | Transmitter may start the frame |

## Verification
Several rules are checked on every cycle by the assertions:
- the grant is low after reset;
- the grant is held until a frame start or a dropped request, and then released;
- the grant rises only under a live request;
- a low line blocks the grant in the next cycle.

Other behaviour can only be shown by the bench's scenarios:
- the exact tick thresholds for each setting and context;
- the two start options;
- ticks ignored before counting begins;
- end pulses ignored in software mode;
- counter saturation over a long idle period.

// File: rtl/cec_sft_pkg.sv
package cec_sft_pkg;

    localparam int SEL_W = 3;
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // default thresholds, in half-bit ticks
    localparam logic [CNT_W-1:0] DEF_RETRY_TICKS   = CNT_W'(5);
    localparam logic [CNT_W-1:0] DEF_NEWINIT_TICKS = CNT_W'(9);
    localparam logic [CNT_W-1:0] DEF_SAME_TICKS    = CNT_W'(13);

    typedef struct packed {
        logic retry;
        logic new_init;
    } sft_ctx_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_GRANT = 2'd2
    } sft_state_t;

    function automatic logic [CNT_W-1:0] sft_threshold(
        input logic [SEL_W-1:0] sel,
        input sft_ctx_t         ctx
    );
        logic [CNT_W-1:0] r;
        if (sel != '0) begin
            r = CNT_W'({1'b0, sel, 1'b0} - 1);
        end else if (ctx.retry) begin
            r = DEF_RETRY_TICKS;
        end else if (ctx.new_init) begin
            r = DEF_NEWINIT_TICKS;
        end else begin
            r = DEF_SAME_TICKS;
        end
        return r;
    endfunction

endpackage

// File: rtl/sft_threshold_sel.sv
module sft_threshold_sel
    import cec_sft_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  sft_ctx_t         ctx,
    input  logic [CNT_W-1:0] count,
    output logic             reached
);
    logic [CNT_W-1:0] thr;

    always_comb begin
        thr     = sft_threshold(sel, ctx);
        reached = (count >= thr);
    end
endmodule

// File: rtl/sft_idle_counter.sv
module sft_idle_counter
    import cec_sft_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (run && tick && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
    import cec_sft_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_start,
    input  logic req,
    input  logic frame_end,
    input  logic line_idle,
    input  logic reached,
    input  logic frame_started,
    output logic cnt_clear,
    output logic cnt_run,
    output logic grant
);
    sft_state_t state, state_nx;
    logic       restart;

    always_comb begin
        restart   = auto_start && frame_end;
        state_nx  = state;
        cnt_clear = 1'b0;
        cnt_run   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clear = 1'b1;
                if ((!auto_start && req) || restart) begin
                    state_nx = ST_COUNT;
                end
            end
            ST_COUNT: begin
                cnt_run   = 1'b1;
                cnt_clear = !line_idle || restart;
                if (!auto_start && !req) begin
                    state_nx = ST_IDLE;
                end else if (req && line_idle && reached && !restart) begin
                    state_nx = ST_GRANT;
                end
            end
            ST_GRANT: begin
                if (frame_started || !req) begin
                    state_nx = (auto_start && !frame_started) ? ST_COUNT : ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign grant = (state == ST_GRANT);
endmodule

// File: rtl/cec_free_time_timer.sv
module cec_free_time_timer
    import cec_sft_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] free_sel,
    input  logic             auto_start,
    input  logic             half_tick,
    input  logic             sw_start_req,
    input  logic             tx_end,
    input  logic             rx_end,
    input  logic             line_idle,
    input  logic             ctx_retry,
    input  logic             ctx_new_init,
    input  logic             frame_started,
    output logic             grant
);
    sft_ctx_t         ctx;
    logic [CNT_W-1:0] count;
    logic             reached;
    logic             cnt_clear;
    logic             cnt_run;

    assign ctx = '{retry: ctx_retry, new_init: ctx_new_init};

    sft_threshold_sel u_thr (
        .sel     (free_sel),
        .ctx     (ctx),
        .count   (count),
        .reached (reached)
    );

    sft_idle_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .run   (cnt_run),
        .tick  (half_tick),
        .count (count)
    );

    sft_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .auto_start    (auto_start),
        .req           (sw_start_req),
        .frame_end     (tx_end || rx_end),
        .line_idle     (line_idle),
        .reached       (reached),
        .frame_started (frame_started),
        .cnt_clear     (cnt_clear),
        .cnt_run       (cnt_run),
        .grant         (grant)
    );
endmodule

// File: rtl/cec_free_time_timer_chk.sv
module cec_free_time_timer_chk (
    input logic clk,
    input logic rst,
    input logic sw_start_req,
    input logic line_idle,
    input logic frame_started,
    input logic grant
);
    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !grant);

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && sw_start_req && !frame_started) |=> grant);

    // R7
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && (frame_started || !sw_start_req)) |=> !grant);

    // R8
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant && !sw_start_req) |=> !grant);

    // R6
    line_busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant && !line_idle) |=> !grant);
endmodule

bind cec_free_time_timer cec_free_time_timer_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .sw_start_req  (sw_start_req),
    .line_idle     (line_idle),
    .frame_started (frame_started),
    .grant         (grant)
);

// File: tb/cec_free_time_timer_tb.sv
module cec_free_time_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] free_sel = '0;
    logic       auto_start = 1'b0;
    logic       half_tick = 1'b0;
    logic       sw_start_req = 1'b0;
    logic       tx_end = 1'b0;
    logic       rx_end = 1'b0;
    logic       line_idle = 1'b1;
    logic       ctx_retry = 1'b0;
    logic       ctx_new_init = 1'b0;
    logic       frame_started = 1'b0;
    logic       grant;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cec_free_time_timer u_dut (
        .clk(clk), .rst(rst), .free_sel(free_sel), .auto_start(auto_start),
        .half_tick(half_tick), .sw_start_req(sw_start_req), .tx_end(tx_end),
        .rx_end(rx_end), .line_idle(line_idle), .ctx_retry(ctx_retry),
        .ctx_new_init(ctx_new_init), .frame_started(frame_started), .grant(grant)
    );

    // {sel[3], auto, retry, new_init, use_rx, ticks[5]}
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1},
        {3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'd5},
        {3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 5'd13},
        {3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 5'd7},
        {3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd5},
        {3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd9},
        {3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd13},
        {3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd5},
        {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd3},
        {3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 5'd11}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: grant=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) half_tick = 1'b1;
            @(negedge clk) half_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse_end(input logic use_rx);
        @(negedge clk);
        if (use_rx) rx_end = 1'b1; else tx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        tx_end = 1'b0;
    endtask

    task automatic finish_frame();
        @(negedge clk) frame_started = 1'b1;
        @(negedge clk) frame_started = 1'b0;
        sw_start_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", grant, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", grant, 1'b0);

        for (int v = 0; v < NV; v++) begin
            free_sel     = VEC[v][11:9];
            auto_start   = VEC[v][8];
            ctx_retry    = VEC[v][7];
            ctx_new_init = VEC[v][6];
            if (auto_start) begin
                sw_start_req = 1'b1;
                pulse_end(VEC[v][5]);   // R5 start at frame end
            end else begin
                @(negedge clk) sw_start_req = 1'b1;  // R4 start at request
                @(negedge clk);
            end
            ticks(int'(VEC[v][4:0]) - 1);
            check("R2/R3 below threshold", grant, 1'b0);
            ticks(1);
            check("R2/R3 at threshold", grant, 1'b1);
            @(negedge clk);
            check("R7 grant held", grant, 1'b1);
            finish_frame();
            check("R7 cleared on frame start", grant, 1'b0);
        end

        // R4: ticks without a request are ignored; threshold 3
        free_sel = 3'd2; auto_start = 1'b0; ctx_retry = 1'b0; ctx_new_init = 1'b0;
        ticks(5);
        check("R4 no request", grant, 1'b0);
        @(negedge clk) sw_start_req = 1'b1;
        @(negedge clk);
        ticks(2);
        check("R4 earlier ticks not counted", grant, 1'b0);
        // R4: withdrawal resets
        @(negedge clk) sw_start_req = 1'b0;
        @(negedge clk) sw_start_req = 1'b1;
        @(negedge clk);
        ticks(2);
        check("R4 withdrawal restarts", grant, 1'b0);
        ticks(1);
        check("R4 grant after restart", grant, 1'b1);
        // R7: withdrawal releases grant
        @(negedge clk) sw_start_req = 1'b0;
        @(negedge clk);
        check("R7 cleared on withdrawal", grant, 1'b0);

        // R6: line low mid count
        @(negedge clk) sw_start_req = 1'b1;
        @(negedge clk);
        ticks(2);
        @(negedge clk) line_idle = 1'b0;
        @(negedge clk) line_idle = 1'b1;
        ticks(2);
        check("R6 line low clears count", grant, 1'b0);
        ticks(1);
        check("R6 grant after recount", grant, 1'b1);
        finish_frame();

        // R9: end pulses ignored in software mode
        @(negedge clk) sw_start_req = 1'b1;
        @(negedge clk);
        ticks(2);
        pulse_end(1'b0);
        pulse_end(1'b1);
        ticks(1);
        check("R9 end pulse ignored", grant, 1'b1);
        finish_frame();

        // R5: auto mode ignores ticks before first frame end
        auto_start = 1'b1;
        sw_start_req = 1'b1;
        ticks(5);
        check("R5 no frame end yet", grant, 1'b0);
        pulse_end(1'b0);
        ticks(2);
        pulse_end(1'b1);    // restart
        ticks(2);
        check("R5 end pulse restarts", grant, 1'b0);
        ticks(1);
        check("R5 grant after restart", grant, 1'b1);
        finish_frame();

        // R10 + R8: long idle with no request, default same-initiator 13
        free_sel = 3'd0;
        pulse_end(1'b0);
        ticks(20);
        check("R8 no grant without request", grant, 1'b0);
        @(negedge clk) sw_start_req = 1'b1;
        @(negedge clk);
        check("R10 saturated count meets 13", grant, 1'b1);
        finish_frame();

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule